// File: doc/BRIEF.md
# DRAM-to-SRAM Protocol Adapter

This block sits between a memory controller that speaks a multiplexed-address, bit-serial DRAM protocol and an external static RAM. In SRAM mode it captures the row address when the row strobe falls and the column address when the column strobe falls. It joins the two into one flat address. It gathers eight serial write bits into a parallel byte and writes that byte to the static RAM in a single strobe. On a read it fetches a whole byte and returns it to the controller one bit per bit strobe.

The controller issues the same strobe sequences in both modes and keeps its existing cycle timing. A slow static RAM of about 100 ns therefore works, and throughput is the same as with DRAM. A mode input, driven from a control register elsewhere, selects the mode. When the mode input is low, every DRAM signal passes through to the DRAM pins one register later and the static RAM is left deselected.

Top module: `dram_sram_bridge`

## Requirements
- R1: With `sram_mode` low, `dram_ras_n`, `dram_cas_n`, `dram_we_n`, `dram_addr` and `dram_dq_out` equal the matching controller inputs one clock later, and `sram_cs_n`, `sram_we_n` and `sram_oe_n` stay high.
- R2: With `sram_mode` high, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are held high one clock after the mode is seen.
- R3: The row is the value of `ctl_addr` in the clock where `ctl_ras_n` is first seen low. The column is the value of `ctl_addr` in the clock where `ctl_cas_n` is first seen low while the row strobe is low. The flat SRAM address is {row, column}, with the row in the upper 12 bits.
- R4: In a write access, `ctl_we_n` is low when the column strobe falls. The next eight clocks with `ctl_bit_stb` high each shift in `ctl_dq_out`, first bit as the MSB. In the clock after the eighth such edge, `sram_cs_n` and `sram_we_n` are low for exactly one clock, with the flat address and the packed byte.
- R5: In a read access, `ctl_we_n` is high when the column strobe falls. In the next clock, `sram_cs_n` and `sram_oe_n` are low for exactly one clock with the flat address, and `sram_we_n` stays high.
- R6: After a read fetch, each of the next eight `ctl_bit_stb` edges puts one bit of the fetched byte on `ctl_dq_in`, MSB first, valid one clock after that edge.
- R7: With `sram_mode` low, `ctl_dq_in` equals `dram_dq_in` one clock later.
- R8: During and after reset, every strobe output is high and `ctl_dq_in` is 0.
- R9: In SRAM mode, `ctl_bit_stb` pulses while no access is open start no static RAM cycle (`sram_cs_n` stays high).
- R10: With the row strobe held low, further column strobes reuse the latched row for each new access (page mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sram_mode | input | 1 | 1 selects static RAM translation, 0 selects DRAM pass-through |
| ctl_ras_n | input | 1 | Controller row strobe |
| ctl_cas_n | input | 1 | Controller column strobe |
| ctl_we_n | input | 1 | Controller write enable, sampled at the column strobe |
| ctl_addr | input | 12 | Controller multiplexed address |
| ctl_bit_stb | input | 1 | One serial data bit moves in each clock this is high |
| ctl_dq_out | input | 1 | Serial write bit from the controller |
| ctl_dq_in | output | 1 | Serial read bit to the controller |
| dram_ras_n | output | 1 | DRAM row strobe |
| dram_cas_n | output | 1 | DRAM column strobe |
| dram_we_n | output | 1 | DRAM write enable |
| dram_addr | output | 12 | DRAM address |
| dram_dq_out | output | 1 | DRAM serial write data |
| dram_dq_in | input | 1 | DRAM serial read data |
| sram_cs_n | output | 1 | SRAM chip select |
| sram_we_n | output | 1 | SRAM write strobe |
| sram_oe_n | output | 1 | SRAM output enable |
| sram_addr | output | 24 | Flat SRAM address {row, column} |
| sram_wdata | output | 8 | SRAM write byte |
| sram_rdata | input | 8 | SRAM read byte |

## Verification
Write bytes with different bit patterns (0xA5, 0x3C, 0x01, 0x80) go to addresses whose row and column halves differ. A swapped half, a reversed bit order or an off-by-one bit count therefore shows up in the scoreboard compare. Reads of the same locations return the bytes serially, which tests both the MSB-first order and the fetch address. One access keeps the row strobe low across two column strobes, which shows whether the row latch is held. Alternating strobe and data patterns in DRAM mode confirm the pass-through and the idle static RAM. Stray bit strobes with no open access confirm that no static RAM cycle starts.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_WRITE = 2'd1,
    ENG_FETCH = 2'd2,
    ENG_READ  = 2'd3
  } eng_state_t;
endpackage

// File: rtl/strobe_latch.sv
module strobe_latch #(
  parameter int ROW_W = 12,
  parameter int COL_W = 12,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int MUX_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [MUX_W-1:0]  addr,
  output logic              start,
  output logic              start_wr,
  output logic [ADDR_W-1:0] start_addr
);
  logic ras_q, cas_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ras_q <= 1'b1;
      cas_q <= 1'b1;
      row_q <= '0;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      if (ras_q && !ras_n) row_q <= addr[ROW_W-1:0];
    end
  end

  always_comb begin
    start      = cas_q && !cas_n && !ras_n && !ras_q;
    start_wr   = !we_n;
    start_addr = {row_q, addr[COL_W-1:0]};
  end

  // R3: the row latch only moves on a row strobe fall
  p_row_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!ras_n && !$past(ras_n)) |=> $stable(row_q));
endmodule

// File: rtl/ser_par_engine.sv
module ser_par_engine
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WORD_W = 8,
  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              start,
  input  logic              start_wr,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              bit_stb,
  input  logic              bit_in,
  input  logic [WORD_W-1:0] sram_rdata,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [WORD_W-1:0] sram_wdata,
  output logic              rd_shift,
  output logic              rd_msb
);
  eng_state_t st;
  logic [WORD_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              last_bit;

  assign last_bit = (cnt == CNT_W'(WORD_W - 1));
  assign rd_shift = (st == ENG_READ) && bit_stb && !start;
  assign rd_msb   = sh[WORD_W-1];

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st         <= ENG_IDLE;
      sh         <= '0;
      cnt        <= '0;
      sram_cs_n  <= 1'b1;
      sram_we_n  <= 1'b1;
      sram_oe_n  <= 1'b1;
      sram_addr  <= '0;
      sram_wdata <= '0;
    end else begin
      sram_cs_n <= 1'b1;
      sram_we_n <= 1'b1;
      sram_oe_n <= 1'b1;
      if (start) begin
        sram_addr <= start_addr;
        cnt       <= '0;
        if (start_wr) begin
          st <= ENG_WRITE;
        end else begin
          st        <= ENG_FETCH;
          sram_cs_n <= 1'b0;
          sram_oe_n <= 1'b0;
        end
      end else begin
        case (st)
          ENG_WRITE: if (bit_stb) begin
            sh  <= {sh[WORD_W-2:0], bit_in};
            cnt <= cnt + 1'b1;
            if (last_bit) begin
              sram_wdata <= {sh[WORD_W-2:0], bit_in};
              sram_cs_n  <= 1'b0;
              sram_we_n  <= 1'b0;
              st         <= ENG_IDLE;
            end
          end
          ENG_FETCH: begin
            sh <= sram_rdata;
            st <= ENG_READ;
          end
          ENG_READ: if (bit_stb) begin
            sh  <= {sh[WORD_W-2:0], 1'b0};
            cnt <= cnt + 1'b1;
            if (last_bit) st <= ENG_IDLE;
          end
          default: st <= ENG_IDLE;
        endcase
      end
    end
  end

  // R4: write strobe is a single-cycle pulse under chip select
  p_we_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(sram_we_n) |=> sram_we_n);
  p_we_cs_r4: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> !sram_cs_n);
  // R5: read enable is a single-cycle pulse, never with write
  p_oe_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    !sram_oe_n |=> sram_oe_n);
  p_oe_we_excl_r5: assert property (@(posedge clk) disable iff (rst)
    sram_oe_n || sram_we_n);
  // R9: no SRAM cycle without an access start or a finished write
  p_no_stray_r9: assert property (@(posedge clk) disable iff (rst)
    (st == ENG_IDLE && !start) |=> sram_cs_n);
endmodule

// File: rtl/dram_sram_bridge.sv
module dram_sram_bridge #(
  parameter int ROW_W = 12,
  parameter int COL_W = 12,
  parameter int WORD_W = 8,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int MUX_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sram_mode,
  input  logic              ctl_ras_n,
  input  logic              ctl_cas_n,
  input  logic              ctl_we_n,
  input  logic [MUX_W-1:0]  ctl_addr,
  input  logic              ctl_bit_stb,
  input  logic              ctl_dq_out,
  output logic              ctl_dq_in,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic [MUX_W-1:0]  dram_addr,
  output logic              dram_dq_out,
  input  logic              dram_dq_in,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [WORD_W-1:0] sram_wdata,
  input  logic [WORD_W-1:0] sram_rdata
);
  logic              acc_start, acc_wr, rd_shift, rd_msb;
  logic [ADDR_W-1:0] acc_addr;

  strobe_latch #(.ROW_W(ROW_W), .COL_W(COL_W)) u_latch (
    .clk(clk), .rst(rst), .ras_n(ctl_ras_n), .cas_n(ctl_cas_n),
    .we_n(ctl_we_n), .addr(ctl_addr), .start(acc_start),
    .start_wr(acc_wr), .start_addr(acc_addr)
  );

  ser_par_engine #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_engine (
    .clk(clk), .rst(rst), .en(sram_mode), .start(acc_start),
    .start_wr(acc_wr), .start_addr(acc_addr), .bit_stb(ctl_bit_stb),
    .bit_in(ctl_dq_out), .sram_rdata(sram_rdata), .sram_cs_n(sram_cs_n),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_addr(sram_addr),
    .sram_wdata(sram_wdata), .rd_shift(rd_shift), .rd_msb(rd_msb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_addr   <= '0;
      dram_dq_out <= 1'b0;
      ctl_dq_in   <= 1'b0;
    end else if (sram_mode) begin
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_addr   <= '0;
      dram_dq_out <= 1'b0;
      if (rd_shift) ctl_dq_in <= rd_msb;
    end else begin
      dram_ras_n  <= ctl_ras_n;
      dram_cas_n  <= ctl_cas_n;
      dram_we_n   <= ctl_we_n;
      dram_addr   <= ctl_addr;
      dram_dq_out <= ctl_dq_out;
      ctl_dq_in   <= dram_dq_in;
    end
  end

  // R1: DRAM mode passes strobes through and leaves the SRAM idle
  p_sram_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !sram_mode |=> sram_cs_n && sram_we_n && sram_oe_n);
  p_dram_pass_r1: assert property (@(posedge clk) disable iff (rst)
    !sram_mode |=> (dram_ras_n == $past(ctl_ras_n)) && (dram_cas_n == $past(ctl_cas_n)));
  // R2: SRAM mode keeps DRAM strobes inactive
  p_dram_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    sram_mode |=> dram_ras_n && dram_cas_n && dram_we_n);
  // R7: DRAM read bit returns to the controller in DRAM mode
  p_dq_pass_r7: assert property (@(posedge clk) disable iff (rst)
    !sram_mode |=> ctl_dq_in == $past(dram_dq_in));
endmodule

// File: tb/sim_dram_sram_bridge.sv
module sim_dram_sram_bridge;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sram_mode = 1'b0;
  logic ctl_ras_n = 1'b1, ctl_cas_n = 1'b1, ctl_we_n = 1'b1;
  logic [11:0] ctl_addr = '0;
  logic ctl_bit_stb = 1'b0, ctl_dq_out = 1'b0, dram_dq_in = 1'b0;
  logic ctl_dq_in, dram_ras_n, dram_cas_n, dram_we_n, dram_dq_out;
  logic [11:0] dram_addr;
  logic sram_cs_n, sram_we_n, sram_oe_n;
  logic [23:0] sram_addr;
  logic [7:0] sram_wdata, sram_rdata;
  logic [7:0] mem [0:255];
  logic [31:0] exp_q [$];
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  dram_sram_bridge u0 (
    .clk(clk), .rst(rst), .sram_mode(sram_mode), .ctl_ras_n(ctl_ras_n),
    .ctl_cas_n(ctl_cas_n), .ctl_we_n(ctl_we_n), .ctl_addr(ctl_addr),
    .ctl_bit_stb(ctl_bit_stb), .ctl_dq_out(ctl_dq_out), .ctl_dq_in(ctl_dq_in),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_addr(dram_addr), .dram_dq_out(dram_dq_out), .dram_dq_in(dram_dq_in),
    .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata)
  );

  always @(posedge clk) if (!sram_cs_n && !sram_we_n) mem[sram_addr[7:0]] <= sram_wdata;
  assign sram_rdata = mem[sram_addr[7:0]];

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  // monitor: pops expected writes as the SRAM write strobe appears
  always @(negedge clk) begin
    if (!rst && !sram_we_n) begin
      if (exp_q.size() == 0) check("R9 unexpected write", {sram_addr, sram_wdata}, 32'hFFFF_FFFF);
      else check("R4 write addr/data", {sram_addr, sram_wdata}, exp_q.pop_front());
    end
  end

  task automatic open_row(input logic [11:0] row);
    @(negedge clk); ctl_ras_n = 1'b0; ctl_addr = row;
  endtask

  task automatic close_row();
    @(negedge clk); ctl_cas_n = 1'b1; ctl_ras_n = 1'b1; ctl_bit_stb = 1'b0;
  endtask

  task automatic wr_col(input logic [11:0] row, input logic [11:0] col, input logic [7:0] d);
    exp_q.push_back({row, col, d});
    @(negedge clk); ctl_cas_n = 1'b1;
    @(negedge clk); ctl_cas_n = 1'b0; ctl_we_n = 1'b0; ctl_addr = col;
    for (int k = 7; k >= 0; k--) begin
      @(negedge clk); ctl_bit_stb = 1'b1; ctl_dq_out = d[k];
    end
    @(negedge clk); ctl_bit_stb = 1'b0; ctl_we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd_col(input logic [11:0] row, input logic [11:0] col, input logic [7:0] d);
    logic [7:0] got;
    @(negedge clk); ctl_cas_n = 1'b1;
    @(negedge clk); ctl_cas_n = 1'b0; ctl_we_n = 1'b1; ctl_addr = col;
    @(negedge clk);
    check("R5 fetch strobes", {29'd0, sram_cs_n, sram_oe_n, sram_we_n}, 32'd1);
    check("R3 R5 fetch address", {8'd0, sram_addr}, {8'd0, row, col});
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (k > 0) got[8-k] = ctl_dq_in;
      ctl_bit_stb = 1'b1;
    end
    @(negedge clk); got[0] = ctl_dq_in; ctl_bit_stb = 1'b0;
    check("R6 serial read byte", {24'd0, got}, {24'd0, d});
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R8 reset strobes",
          {25'd0, dram_ras_n, dram_cas_n, dram_we_n, sram_cs_n, sram_we_n, sram_oe_n, ctl_dq_in},
          {25'd0, 7'b1111110});
    @(negedge clk); rst = 1'b0;
    // DRAM pass-through patterns
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      ctl_ras_n = i[0]; ctl_cas_n = i[1]; ctl_we_n = ~i[0];
      ctl_addr = 12'h5A0 + 12'(i); ctl_dq_out = i[1]; dram_dq_in = ~i[1];
      @(negedge clk);
      check("R1 pass-through", {15'd0, dram_ras_n, dram_cas_n, dram_we_n, dram_addr, dram_dq_out, sram_cs_n},
            {15'd0, i[0], i[1], ~i[0], 12'h5A0 + 12'(i), i[1], 1'b1});
      check("R7 read bit pass", {31'd0, ctl_dq_in}, {31'd0, ~i[1]});
    end
    @(negedge clk); ctl_ras_n = 1'b1; ctl_cas_n = 1'b1; ctl_we_n = 1'b1; sram_mode = 1'b1;
    @(negedge clk); ctl_ras_n = 1'b0;
    @(negedge clk);
    check("R2 DRAM quiet", {29'd0, dram_ras_n, dram_cas_n, dram_we_n}, 32'd7);
    ctl_ras_n = 1'b1;
    // R9: stray bit strobes with no access open
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); ctl_bit_stb = i[0]; ctl_dq_out = 1'b1;
      if (i > 0) check("R9 no stray cycle", {31'd0, sram_cs_n}, 32'd1);
    end
    ctl_bit_stb = 1'b0;
    // writes: R3 R4, second one in page mode (R10)
    open_row(12'h123); wr_col(12'h123, 12'h4A5, 8'hA5); close_row();
    open_row(12'hABC); wr_col(12'hABC, 12'h03C, 8'h3C);
    wr_col(12'hABC, 12'h701, 8'h01); close_row();  // R10 page mode
    open_row(12'h800); wr_col(12'h800, 12'hF80, 8'h80); close_row();
    check("R4 all writes seen", exp_q.size(), 32'd0);
    // reads
    open_row(12'h123); rd_col(12'h123, 12'h4A5, 8'hA5); close_row();
    open_row(12'hABC); rd_col(12'hABC, 12'h03C, 8'h3C);
    rd_col(12'hABC, 12'h701, 8'h01); close_row();  // R10 page mode read
    open_row(12'h800); rd_col(12'h800, 12'hF80, 8'h80); close_row();
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule